// File: doc/BRIEF.md
# Gated Serial Clock Divider

This block derives the serial clock for a memory sequencer from the reference clock. The serial clock runs at a power-of-two fraction of the reference rate. A one-cycle sampling strobe marks either the end of each high half-period or its middle. Two enable inputs, one for normal traffic and one for the boot path, keep the clock running while either of them is set.

Software clears both enables before it reprograms the divider or the phase. It then waits for the stopped flag, the idle flag and a quiet host bus before it writes new settings. The stop never cuts a high pulse short. The divider and phase settings only take hold while the clock is stopped, so a write that lands while the clock runs has no effect until the next stop. When an enable is set again, the stopped flag drops to confirm the restart.

Top module: `sclkg_gen`

## Requirements
- R1: While reset is asserted, `sclk` and `samp_stb` are 0, `clk_stopped` is 1 and `ser_idle` is 0.
- R2: While running, every high and every low half-period of `sclk` lasts 2^`div_sel` reference cycles. Codes 0, 1, 2 and 3 divide by 1, 2, 4 and 8, and the full period is twice the half-period.
- R3: If either `run_en` or `boot_en` is 1 at a clock edge while the clock is stopped, `clk_stopped` is 0 after that edge. `sclk` then stays low for one half-period before its first rise.
- R4: After both enables go low, the block stops at the first edge where `sclk` is, or falls to, 0. `clk_stopped` rises at that same edge. If `sclk` was high in cycle index i of its high half-period, the stop takes H−i cycles. If `sclk` was low, it takes one cycle. While stopped, `sclk` and `samp_stb` stay 0.
- R5: No high pulse of `sclk` is shorter than a full half-period, including the last pulse before a stop.
- R6: Changes to `div_sel` and `phase_sel` while the clock runs or is stopping have no effect on `sclk` or `samp_stb`. The values present in the last stopped cycle are the ones used after a restart.
- R7: `samp_stb` is 1 only while `sclk` is high. With phase 0 (180°) it is 1 in the last cycle of each high half-period. With phase 1 (90°) it is 1 in cycle index H/2 of that half-period, or index 0 when H is 1.
- R8: `ser_idle` equals the inverse of `seq_busy` as sampled at the previous clock edge.
- R9: `cfg_ok` is 1 exactly when `clk_stopped` and `ser_idle` are 1 and `bus_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Normal-operation clock enable |
| boot_en | input | 1 | Boot-path clock enable |
| div_sel | input | DIV_W | Divider code; half-period is 2^code cycles |
| phase_sel | input | 1 | Strobe phase: 0 = 180°, 1 = 90° |
| seq_busy | input | 1 | Sequencer serial side busy |
| bus_busy | input | 1 | Host bus read or write in progress |
| sclk | output | 1 | Gated, divided serial clock |
| samp_stb | output | 1 | One-cycle sampling strobe |
| clk_stopped | output | 1 | Internal clock has stopped |
| ser_idle | output | 1 | Registered serial-side idle status |
| cfg_ok | output | 1 | Configuration may be changed safely |

## Verification
The bench builds the block with the default DIV_W of 2. This makes all four divider codes reachable, up to a high half-period of eight cycles. As a result, every strobe index and every stop offset within the longest pulse can be reached by a random stop point. Random runs scramble the divider and phase inputs while the clock is live, which tests that settings only take hold while stopped. Random busy inputs cover the status outputs in every cycle.

// File: rtl/sclkg_pkg.sv
package sclkg_pkg;

  // half-period length in reference cycles for a divider code
  function automatic int unsigned half_len(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // cycle index inside the high half-period where the strobe fires
  function automatic int unsigned strobe_idx(input int unsigned code, input logic ph);
    return ph ? (half_len(code) >> 1) : (half_len(code) - 32'd1);
  endfunction

endpackage

// File: rtl/sclkg_div_core.sv
module sclkg_div_core
  import sclkg_pkg::*;
#(
  parameter int DIV_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             halt,
  input  logic [DIV_W-1:0] code,
  input  logic             ph,
  output logic             sclk,
  output logic             stb,
  output logic             fall_now
);

  logic [CNT_W-1:0] cnt;
  logic             sclk_r;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] sidx;
  logic             at_end;

  assign lim      = CNT_W'(half_len(32'(code)) - 32'd1);
  assign sidx     = CNT_W'(strobe_idx(32'(code), ph));
  assign at_end   = (cnt == lim);
  assign fall_now = run & sclk_r & at_end;
  assign stb      = run & sclk_r & (cnt == sidx);
  assign sclk     = sclk_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_r <= 1'b0;
    end else if (!run || (halt && !sclk_r)) begin
      cnt    <= '0;
      sclk_r <= 1'b0;
    end else if (at_end) begin
      cnt    <= '0;
      sclk_r <= ~sclk_r;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  // checker counter: length of the current high pulse
  logic [CNT_W:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len <= '0;
    else if (sclk_r) hi_len <= hi_len + 1'b1;
    else             hi_len <= '0;
  end

  // R5
  hi_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_r) |-> hi_len == (CNT_W+1)'(half_len(32'(code))));

endmodule

// File: rtl/sclkg_gate_ctl.sv
module sclkg_gate_ctl #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_run,
  input  logic             en_boot,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             phase_sel,
  input  logic             sclk,
  input  logic             fall_now,
  output logic             running,
  output logic             halt,
  output logic [DIV_W-1:0] div_act,
  output logic             ph_act
);

  logic running_n;

  assign halt = ~(en_run | en_boot);

  always_comb begin
    if (running) running_n = !(halt && (!sclk || fall_now));
    else         running_n = !halt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      div_act <= '0;
      ph_act  <= 1'b0;
    end else begin
      running <= running_n;
      if (!running) begin
        div_act <= div_sel;
        ph_act  <= phase_sel;
      end
    end
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(div_act) && $stable(ph_act)));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !halt) |=> running);

  // R4
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && halt && !sclk) |=> !running);

endmodule

// File: rtl/sclkg_gen.sv
module sclkg_gen #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             boot_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             phase_sel,
  input  logic             seq_busy,
  input  logic             bus_busy,
  output logic             sclk,
  output logic             samp_stb,
  output logic             clk_stopped,
  output logic             ser_idle,
  output logic             cfg_ok
);

  localparam int CNT_W = (2 ** DIV_W) - 1;

  logic             running;
  logic             halt;
  logic             fall_now;
  logic [DIV_W-1:0] div_act;
  logic             ph_act;

  sclkg_gate_ctl #(.DIV_W(DIV_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_run    (run_en),
    .en_boot   (boot_en),
    .div_sel   (div_sel),
    .phase_sel (phase_sel),
    .sclk      (sclk),
    .fall_now  (fall_now),
    .running   (running),
    .halt      (halt),
    .div_act   (div_act),
    .ph_act    (ph_act)
  );

  sclkg_div_core #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (running),
    .halt     (halt),
    .code     (div_act),
    .ph       (ph_act),
    .sclk     (sclk),
    .stb      (samp_stb),
    .fall_now (fall_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_idle <= 1'b0;
    else        ser_idle <= ~seq_busy;
  end

  assign clk_stopped = ~running;
  assign cfg_ok      = clk_stopped & ser_idle & ~bus_busy;

  // R4
  sclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !clk_stopped);

  // R7
  stb_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |-> sclk);

endmodule

// File: tb/tb_sclkg_gen.sv
module tb_sclkg_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0, boot_en = 1'b0, phase_sel = 1'b0;
  logic       seq_busy = 1'b1, bus_busy = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       sclk, samp_stb, clk_stopped, ser_idle, cfg_ok;

  int  total = 0, bad = 0;
  logic prev_seq = 1'b1;
  bit  finished = 0;

  int  h_cur, sidx_cur, run_len, done_len;
  logic last_s;
  string tag;

  sclkg_gen #(.DIV_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .boot_en(boot_en),
    .div_sel(div_sel), .phase_sel(phase_sel), .seq_busy(seq_busy),
    .bus_busy(bus_busy), .sclk(sclk), .samp_stb(samp_stb),
    .clk_stopped(clk_stopped), .ser_idle(ser_idle), .cfg_ok(cfg_ok)
  );

  always #5 clk = ~clk;

  function automatic int exp_half(input int code);
    int h = 1;
    for (int k = 0; k < code; k++) h = h * 2;
    return h;
  endfunction

  function automatic int exp_sidx(input int code, input bit ph);
    int h = exp_half(code);
    if (ph) return h / 2;
    return h - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance one cycle; check status outputs (R8, R9); re-randomize busy inputs
  task automatic tick();
    @(negedge clk);
    chk(ser_idle == !prev_seq, "R8", ser_idle, !prev_seq);
    chk(cfg_ok == (clk_stopped & ser_idle & !bus_busy), "R9", cfg_ok,
        clk_stopped & ser_idle & !bus_busy);
    seq_busy = 1'($urandom);
    bus_busy = 1'($urandom);
    prev_seq = seq_busy;
  endtask

  // tick plus tracking of sclk half-periods and strobe position
  task automatic obs();
    tick();
    if (sclk == last_s) run_len++;
    else begin
      chk(run_len == h_cur, tag, run_len, h_cur);
      done_len = run_len;
      run_len = 1;
      last_s = sclk;
    end
    if (sclk) chk(samp_stb == ((run_len - 1) == sidx_cur), "R7", samp_stb,
                  (run_len - 1) == sidx_cur);
    else      chk(samp_stb == 1'b0, "R7", samp_stb, 0);
  endtask

  task automatic do_run(input int code, input bit ph, input bit rb, input bit bb,
                        input int nhalves, input bit perturb);
    int extra, lat, idx;
    logic s;
    div_sel = 2'(code); phase_sel = ph; run_en = rb; boot_en = bb;
    h_cur = exp_half(code); sidx_cur = exp_sidx(code, ph);
    tag = perturb ? "R6" : "R2";
    tick();
    chk(clk_stopped == 1'b0, "R3", clk_stopped, 0);
    chk(sclk == 1'b0, "R3", sclk, 0);
    run_len = 1; last_s = 1'b0;
    for (int n = 0; n < nhalves * 2 * h_cur; n++) begin
      if (perturb) begin div_sel = 2'($urandom); phase_sel = 1'($urandom); end
      obs();
    end
    extra = $urandom_range(0, 2 * h_cur - 1);
    for (int n = 0; n < extra; n++) begin
      if (perturb) begin div_sel = 2'($urandom); phase_sel = 1'($urandom); end
      obs();
    end
    s = sclk; idx = run_len - 1;
    run_en = 1'b0; boot_en = 1'b0;
    lat = s ? (h_cur - idx) : 1;
    for (int k = 1; k <= lat; k++) begin
      if (perturb) begin div_sel = 2'($urandom); phase_sel = 1'($urandom); end
      obs();
      if (k < lat) chk(clk_stopped == 1'b0 && sclk == 1'b1, "R4", clk_stopped, 0);
      else begin
        chk(clk_stopped == 1'b1, "R4", clk_stopped, 1);
        chk(sclk == 1'b0, "R4", sclk, 0);
        if (s) chk(done_len == h_cur, "R5", done_len, h_cur);
      end
    end
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(clk_stopped && !sclk && !samp_stb, "R4", {clk_stopped, sclk, samp_stb}, 3'b100);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk == 1'b0, "R1", sclk, 0);
    chk(samp_stb == 1'b0, "R1", samp_stb, 0);
    chk(clk_stopped == 1'b1, "R1", clk_stopped, 1);
    chk(ser_idle == 1'b0, "R1", ser_idle, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 2; p++)
        do_run(c, p[0], 1'b1, 1'b0, 3, 1'b0);
    do_run(2, 1'b1, 1'b0, 1'b1, 2, 1'b0);   // boot enable only (R3)
    do_run(3, 1'b0, 1'b1, 1'b1, 2, 1'b1);   // R6 perturb on slowest
    for (int r = 0; r < 24; r++) begin
      int rb = $urandom_range(0, 2);
      do_run($urandom_range(0, 3), 1'($urandom), rb != 1, rb != 0,
             $urandom_range(1, 3), 1'($urandom));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog (all) act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule